// File: doc/BRIEF.md
# Strobe-Timed Memory Cycle Controller

This block sits between a host request channel and an asynchronous, enable-strobed static memory that is one bit wide. The host hands over one read or write at a time with a valid/ready handshake. Each request carries an address and one bit of write data. The controller turns the request into a memory cycle made of five phases: idle, address setup, strobe low, read capture and recovery. It drives an active-low enable, an active-low write strobe, the address lines and the data-in line. Each phase lasts for a number of system clock cycles. That number is derived when the design is elaborated, by rounding each nanosecond minimum up to whole clock periods.

For a read, the enable is held low past the access time. The data line is sampled on the last clock edge of the low phase, and the sampled bit is returned with a one-cycle response pulse. A write uses early-write ordering by default: the write strobe falls together with the address phase, before the enable falls, and rises only when the enable rises. A parameter selects a variant in which the write strobe falls in the same cycle as the enable. After each cycle the enable stays high for a recovery period. This period covers the minimum high time, the output release time and the minimum fall-to-fall interval, and only then is a new request taken.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, req_ready is 1, mem_en_n is 1, mem_we_n is 1, rsp_valid is 0, and mem_addr and mem_din are 0.
- R2: req_ready is 1 only when the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 in the following cycle.
- R3: From the cycle after a request is taken, mem_addr and mem_din carry that request's address and data. They hold those values until the next request is taken, whatever the request inputs do in between.
- R4: After a request is taken, mem_en_n stays 1 for SETUP_CYC cycles (1 with default parameters) and then falls.
- R5: For a write, mem_en_n stays 0 for LOW_CYC cycles. LOW_CYC is the largest of the enable-low width, the write-pulse width, the write lead before the enable rises, the address hold and the data hold, each rounded up to clock cycles (6 by default).
- R6: For a read, mem_en_n stays 0 for LOW_CYC + CAP_CYC cycles, where CAP_CYC is at least 1 and makes the sum cover the access time. mem_q is sampled at the clock edge that ends the low phase. In the next cycle rsp_valid is 1 for exactly one cycle, with rsp_rdata equal to the sampled bit. A write produces no response.
- R7: For a read, mem_we_n is 1 throughout the cycle.
- R8: For a write with EARLY_WRITE=1 (the default), mem_we_n is 0 from the cycle after the request is taken, which is before mem_en_n falls, and returns to 1 in the same cycle that mem_en_n returns to 1. With EARLY_WRITE=0, mem_we_n falls in the same cycle as mem_en_n. mem_we_n never falls while mem_en_n is already 0.
- R9: After mem_en_n rises, it stays 1 for REC_CYC cycles before req_ready returns to 1. REC_CYC is the largest of the enable-high time, the output release time and the cycle time minus LOW_CYC (3 by default). A read therefore occupies 11 cycles after acceptance and a write 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 1 | Read data bit |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_en_n | output | 1 | Active-low enable strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_din | output | 1 | Data-in line to the memory |
| mem_q | input | 1 | Data-out line from the memory |

## Verification
The bench drives isolated writes and reads at the two address extremes and at alternating-bit addresses. This tells apart address routing errors and data inversion. Back-to-back requests, with req_valid held high and the request fields changing while the controller is busy, show whether a request is taken early and whether the address and data stay held during a cycle. Reads of locations never written, and reads right after writes to the same location, show whether the write strobe actually reaches the memory model. The memory model drives the wrong bit until the access time has passed, so a read that samples early is caught.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_LOW     = 3'd2,
      ST_CAPTURE = 3'd3,
      ST_RECOVER = 3'd4
   } mcc_state_t;

   // Whole clock cycles needed to cover a time in ns (rounded up).
   function automatic int ns2cyc(input int t_ns, input int clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mcc_phase_timer.sv
module mcc_phase_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/mcc_read_capture.sv
module mcc_read_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic q_in,
   output logic rsp_valid,
   output logic rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= 1'b0;
      end else begin
         rsp_valid <= strobe;
         if (strobe)
            rsp_rdata <= q_in;
      end
   end

endmodule

// File: rtl/mem_cycle_ctrl.sv
module mem_cycle_ctrl
   import mcc_pkg::*;
#(
   parameter int ADDR_W          = 12,
   parameter int CLK_NS          = 20,
   parameter int T_ADDR_SETUP_NS = 0,
   parameter int T_ADDR_HOLD_NS  = 40,
   parameter int T_EN_LOW_NS     = 120,
   parameter int T_EN_HIGH_NS    = 50,
   parameter int T_CYCLE_NS      = 170,
   parameter int T_ACCESS_NS     = 120,
   parameter int T_WR_PULSE_NS   = 70,
   parameter int T_WR_LEAD_NS    = 70,
   parameter int T_DATA_HOLD_NS  = 25,
   parameter int T_OUT_OFF_NS    = 50,
   parameter bit EARLY_WRITE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wdata,
   output logic              rsp_valid,
   output logic              rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_en_n,
   output logic              mem_we_n,
   output logic              mem_din,
   input  logic              mem_q
);

   // Phase lengths in clock cycles
   localparam int SETUP_CYC = imax(1, ns2cyc(T_ADDR_SETUP_NS, CLK_NS));
   localparam int LOW_CYC   = imax(1, imax(imax(ns2cyc(T_EN_LOW_NS, CLK_NS),
                                                ns2cyc(T_WR_PULSE_NS, CLK_NS)),
                                           imax(ns2cyc(T_WR_LEAD_NS, CLK_NS),
                                                imax(ns2cyc(T_ADDR_HOLD_NS, CLK_NS),
                                                     ns2cyc(T_DATA_HOLD_NS, CLK_NS)))));
   localparam int CAP_CYC   = imax(1, ns2cyc(T_ACCESS_NS, CLK_NS) - LOW_CYC);
   localparam int REC_CYC   = imax(1, imax(imax(ns2cyc(T_EN_HIGH_NS, CLK_NS),
                                                ns2cyc(T_OUT_OFF_NS, CLK_NS)),
                                           ns2cyc(T_CYCLE_NS, CLK_NS) - LOW_CYC));
   localparam int MAX_CYC   = imax(imax(SETUP_CYC, LOW_CYC), imax(CAP_CYC, REC_CYC));
   localparam int CW        = imax(1, $clog2(MAX_CYC + 1));

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("mem_cycle_ctrl: ADDR_W must be 1..32");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("mem_cycle_ctrl: CLK_NS must be positive");
   end
   if (T_ADDR_SETUP_NS < 0 || T_ADDR_HOLD_NS < 0 || T_EN_LOW_NS < 0 ||
       T_EN_HIGH_NS < 0 || T_CYCLE_NS < 0 || T_ACCESS_NS < 0 ||
       T_WR_PULSE_NS < 0 || T_WR_LEAD_NS < 0 || T_DATA_HOLD_NS < 0 ||
       T_OUT_OFF_NS < 0) begin : g_bad_time
      $error("mem_cycle_ctrl: timing minimums must not be negative");
   end

   mcc_state_t        state_q, state_d;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              din_q;
   logic              tmr_load;
   logic [CW-1:0]     tmr_val;
   logic              tmr_zero;
   logic              accept;
   logic              we_on;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = CW'(SETUP_CYC - 1);
         end
         ST_SETUP: if (tmr_zero) begin
            state_d  = ST_LOW;
            tmr_load = 1'b1;
            tmr_val  = CW'(LOW_CYC - 1);
         end
         ST_LOW: if (tmr_zero) begin
            tmr_load = 1'b1;
            if (wr_q) begin
               state_d = ST_RECOVER;
               tmr_val = CW'(REC_CYC - 1);
            end else begin
               state_d = ST_CAPTURE;
               tmr_val = CW'(CAP_CYC - 1);
            end
         end
         ST_CAPTURE: if (tmr_zero) begin
            state_d  = ST_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = CW'(REC_CYC - 1);
         end
         ST_RECOVER: if (tmr_zero) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         din_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            din_q  <= req_wdata;
         end
      end
   end

   mcc_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   // Write strobe placement
   if (EARLY_WRITE) begin : g_early_we
      assign we_on = wr_q && ((state_q == ST_SETUP) || (state_q == ST_LOW));
   end else begin : g_late_we
      assign we_on = wr_q && (state_q == ST_LOW);
   end

   assign mem_en_n = !((state_q == ST_LOW) || (state_q == ST_CAPTURE));
   assign mem_we_n = !we_on;
   assign mem_addr = addr_q;
   assign mem_din  = din_q;

   mcc_read_capture u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    ((state_q == ST_CAPTURE) && tmr_zero),
      .q_in      (mem_q),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
   parameter int ADDR_W  = 12,
   parameter int LOW_CYC = 6,
   parameter int REC_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_din,
   input logic              mem_en_n,
   input logic              mem_we_n,
   input logic              rsp_valid
);

   logic [15:0] low_cnt;
   logic [15:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         high_cnt <= 16'(REC_CYC);
      end else begin
         low_cnt  <= mem_en_n ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 1'b1);
         high_cnt <= !mem_en_n ? '0 : ((high_cnt == '1) ? high_cnt : high_cnt + 1'b1);
      end
   end

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (req_ready && mem_en_n && mem_we_n && !rsp_valid));

   a_r2_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_addr_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(mem_addr) && $stable(mem_din)));

   a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_en_n) |-> (low_cnt >= 16'(LOW_CYC)));

   a_r9_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_en_n) |-> (high_cnt >= 16'(REC_CYC)));

   a_r7_no_we_fall_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_en_n && $past(!mem_en_n)) |-> !$fell(mem_we_n));

   a_r8_we_rise_with_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_en_n);

   a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r6_rsp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (mem_en_n && $past(!mem_en_n)));

endmodule

bind mem_cycle_ctrl mcc_checker #(
   .ADDR_W  (ADDR_W),
   .LOW_CYC (LOW_CYC),
   .REC_CYC (REC_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .mem_addr  (mem_addr),
   .mem_din   (mem_din),
   .mem_en_n  (mem_en_n),
   .mem_we_n  (mem_we_n),
   .rsp_valid (rsp_valid)
);

// File: tb/mem_cycle_ctrl_tb.sv
module mem_cycle_ctrl_tb;

   localparam int AW  = 12;
   localparam int TCK = 20;
   // Phase lengths worked out from the nanosecond minimums at 20 ns
   localparam int S_C = 1;                 // setup 0 ns, at least one cycle
   localparam int L_C = (120 + TCK - 1) / TCK;  // 6: largest of 120/70/70/40/25
   localparam int C_C = 1;                 // access 120 ns already covered, one extra
   localparam int R_C = (170 + TCK - 1) / TCK - L_C; // 9-6=3 (>= 50 ns terms)
   localparam int ACC = (120 + TCK - 1) / TCK;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_wdata = 1'b0;
   logic          req_ready, rsp_valid, rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_en_n, mem_we_n, mem_din;
   logic          mem_q = 1'b0;

   always #(TCK/2) clk = ~clk;

   mem_cycle_ctrl u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .mem_addr (mem_addr), .mem_en_n (mem_en_n), .mem_we_n (mem_we_n),
      .mem_din (mem_din), .mem_q (mem_q)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   bit            ram    [4096];
   bit            shadow [4096];
   logic [AW-1:0] lat_a = '0;
   int            age = 0;
   logic          prev_en = 1'b1;
   logic          wr_seen = 1'b0;
   logic          wr_bit = 1'b0;

   initial begin
      for (int i = 0; i < 4096; i++) begin
         ram[i]    = ^(i * 37 + 5);
         shadow[i] = ram[i];
      end
   end

   always @(negedge clk) begin
      if (!mem_en_n && prev_en) begin
         lat_a   = mem_addr;
         wr_seen = 1'b0;
      end
      if (!mem_en_n) begin
         age++;
         if (!mem_we_n) begin
            wr_seen = 1'b1;
            wr_bit  = mem_din;
         end
      end else begin
         if (!prev_en && wr_seen) ram[lat_a] = wr_bit;
         age = 0;
      end
      prev_en = mem_en_n;
      // wrong bit until access time has elapsed or when not reading
      mem_q = (!mem_en_n && mem_we_n && age >= ACC) ? ram[lat_a] : ~ram[lat_a];
   end

   // ---------------- reference model ----------------
   bit            m_busy = 0;
   int            m_t = 0;
   int            m_tot = 0;
   bit            m_wr = 0;
   logic [AW-1:0] m_a = '0;
   logic          m_d = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_t = 0; m_a = '0; m_d = 1'b0; m_wr = 0;
      end else if (m_busy) begin
         m_t++;
         if (m_t > m_tot) m_busy = 0;
      end else if (req_valid) begin
         m_busy = 1; m_t = 1;
         m_wr = req_write; m_a = req_addr; m_d = req_wdata;
         m_tot = m_wr ? (S_C + L_C + R_C) : (S_C + L_C + C_C + R_C);
         if (m_wr) shadow[m_a] = m_d;
      end
   end

   bit cmp_on = 0;

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         bit    e_ready, e_low, e_we, e_rsp;
         string ten;
         e_ready = !m_busy;
         e_low   = m_busy && (m_t > S_C) && (m_t <= S_C + L_C + (m_wr ? 0 : C_C));
         e_we    = m_busy && m_wr && (m_t <= S_C + L_C);
         e_rsp   = m_busy && !m_wr && (m_t == S_C + L_C + C_C + 1);
         if (m_busy && m_t <= S_C) ten = "R4";
         else if (m_busy && m_t > S_C + L_C + (m_wr ? 0 : C_C)) ten = "R9";
         else if (m_busy && !m_wr) ten = "R6";
         else ten = "R5";
         chk("R2", "req_ready", int'(req_ready), int'(e_ready));
         chk(ten, "mem_en_n", int'(mem_en_n), int'(!e_low));
         chk(m_wr ? "R8" : "R7", "mem_we_n", int'(mem_we_n), int'(!e_we));
         chk("R3", "mem_addr", int'(mem_addr), int'(m_a));
         chk("R3", "mem_din", int'(mem_din), int'(m_d));
         chk("R6", "rsp_valid", int'(rsp_valid), int'(e_rsp));
         if (e_rsp) chk("R6", "rsp_rdata", int'(rsp_rdata), int'(shadow[m_a]));
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit wr, input int a, input bit d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      // scramble the inputs while busy: must be ignored (R3)
      req_addr  = ~AW'(a);
      req_wdata = ~d;
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: state during reset
      chk("R1", "reset req_ready", int'(req_ready), 1);
      chk("R1", "reset mem_en_n", int'(mem_en_n), 1);
      chk("R1", "reset mem_we_n", int'(mem_we_n), 1);
      chk("R1", "reset rsp_valid", int'(rsp_valid), 0);
      chk("R1", "reset mem_addr", int'(mem_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1;
      chk("R1", "post-reset req_ready", int'(req_ready), 1);

      // isolated writes at extremes and alternating patterns
      issue(1, 0,     1); wait_idle();
      issue(1, 4095,  0); wait_idle();
      issue(1, 'h555, 1); wait_idle();
      issue(1, 'hAAA, 0); wait_idle();
      // read back
      issue(0, 0,     0); wait_idle();
      issue(0, 4095,  0); wait_idle();
      issue(0, 'h555, 0); wait_idle();
      issue(0, 'hAAA, 0); wait_idle();
      // unwritten locations
      issue(0, 'h7FF, 0); wait_idle();
      issue(0, 'h123, 0); wait_idle();
      // back-to-back with valid held and fields changing while busy
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 'h0F0; req_wdata = ~shadow['h0F0];
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         req_addr  = AW'(k * 97);
         req_write = k[0];
         req_wdata = k[1];
      end
      req_valid = 1'b0;
      wait_idle();
      // read-after-write same location, both polarities
      issue(1, 'h3C3, 1); issue(0, 'h3C3, 0);
      issue(1, 'h3C3, 0); issue(0, 'h3C3, 0);
      issue(0, 'h0F0, 0);
      wait_idle();
      repeat (10) @(negedge clk);
      summary();
      $finish;
   end

endmodule